// File: doc/BRIEF.md
# Serial Host Register Interface

This block is a serial slave through which a host microcontroller loads and reads a codec's registers. The host owns the serial clock. It frames each transaction by pulling chip select low and sends a one-byte command first. That byte selects a register address and, through a fixed length table, sets how many data bytes follow (none, one or two) and which way they travel. Bits are taken from the host's data line on rising serial-clock edges. Reply bits change on falling edges. Both directions send the most significant bit first.

All host pins are brought into the system clock domain through two-stage synchronisers. A completed write shows up inside the chip as a single-cycle strobe with an address and a 16-bit data word. A read command puts its address on a read port, and the returned word is shifted out on the reply line. One command value has no data bytes and produces a one-cycle reset strobe instead. If chip select rises before the expected byte count is reached, the transaction is dropped and no register is touched. An active-low interrupt request pin carries the chip's internal request to the host, delayed by one register.

Top module: `shi_host_if`

## Requirements
- R1: While reset is held and in the cycles after it, `wr_stb` and `cmd_rst` are 0, `host_miso` is 0, and `host_irq_n` is 1 when `irq_req` is 0.
- R2: Command and data bits are taken on rising edges of `host_sclk`, most significant bit first. The first bit after chip select falls is command bit 7.
- R3: A command in 0x70–0x7F or 0xD0–0xDF takes two data bytes. After the 24th rising edge, one `wr_stb` pulse appears with `wr_addr` equal to the command and `wr_data` equal to the first data byte in bits 15:8 and the second in bits 7:0.
- R4: A command in 0x60–0x6F takes one data byte. Its strobe carries `wr_data` = {8'h00, byte}.
- R5: A command in 0xE0–0xEF is a two-byte read. `rd_addr` equals the command. The word `rd_data[15:0]` is shifted out on `host_miso`, bit 15 first. Each bit changes on a falling edge, starting with the falling edge after the 8th rising edge, so the host can sample it on the next rising edge.
- R6: A command in 0xF0–0xFF is a one-byte read that returns `rd_data[7:0]` the same way in eight bits.
- R7: Command 0x01 has no data bytes. It gives exactly one `cmd_rst` pulse after its 8th bit and no `wr_stb`.
- R8: If chip select rises before the last expected bit, the transaction ends with no `wr_stb` and no `cmd_rst`.
- R9: Bits clocked after the expected count, before chip select rises, are ignored: no further strobe is issued.
- R10: Command values outside the table have no data bytes and produce no strobe.
- R11: `wr_stb` is never high for two cycles in a row.
- R12: `host_irq_n` equals the inverse of `irq_req` from the previous clock cycle.
- R13: `host_miso` is 0 except while reply bits of a read are being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sclk | input | 1 | Serial clock from the host |
| host_csn | input | 1 | Active-low transaction frame from the host |
| host_mosi | input | 1 | Serial data from the host |
| host_miso | output | 1 | Serial reply data to the host |
| irq_req | input | 1 | Internal interrupt request, active high |
| host_irq_n | output | 1 | Interrupt request to the host, active low |
| rd_addr | output | 8 | Register address of the current read |
| rd_data | input | 16 | Read value returned for `rd_addr` |
| wr_addr | output | 8 | Address of the completed write |
| wr_data | output | 16 | Data of the completed write |
| wr_stb | output | 1 | One-cycle write strobe |
| cmd_rst | output | 1 | One-cycle reset-command strobe |

## Verification
The hardest case is where the read reply lines up with the host's clock. The word has to be loaded on the one falling edge that follows the command byte, after the synchroniser delay, and it has to be stable before the host's next rising edge. The bench reproduces this by driving host frames with a serial half-period many system clocks long. It samples `host_miso` just before each rising edge and compares every bit with the model's word. Frames cut short, frames padded with extra bits, and unlisted command values are mixed in with normal ones, so that a strobe nobody expects is caught by the every-clock monitor.

// File: rtl/shi_pkg.sv
package shi_pkg;

    localparam int unsigned CMD_W  = 8;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 2 * BYTE_W;

    localparam logic [CMD_W-1:0] RST_CMD = 8'h01;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_WR,
        PH_RD,
        PH_DONE
    } shi_phase_e;

    typedef struct packed {
        logic [1:0] nbytes;
        logic       is_rd;
    } shi_len_t;

    // Command length table: upper nibble selects data byte count and direction.
    function automatic shi_len_t shi_lookup(input logic [CMD_W-1:0] c);
        shi_len_t r;
        r = '0;
        case (c[7:4])
            4'h6:       r = '{nbytes: 2'd1, is_rd: 1'b0};
            4'h7, 4'hD: r = '{nbytes: 2'd2, is_rd: 1'b0};
            4'hE:       r = '{nbytes: 2'd2, is_rd: 1'b1};
            4'hF:       r = '{nbytes: 2'd1, is_rd: 1'b1};
            default:    r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/shi_sync.sv
module shi_sync #(
    parameter int unsigned WIDTH              = 3,
    parameter int unsigned STAGES             = 2,
    parameter logic [WIDTH-1:0] RESET_VAL     = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = din;
        end else begin : g_next
            assign stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RESET_VAL;
            else        stage_q[s] <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/shi_irq.sv
module shi_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    output logic irq_n
);

    logic irq_n_d, irq_n_q;

    always_comb irq_n_d = ~irq_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= irq_n_d;
    end

    assign irq_n = irq_n_q;

endmodule

// File: rtl/shi_core.sv
module shi_core
    import shi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              mosi_s,
    input  logic [WORD_W-1:0] rd_data,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              wr_stb_o,
    output logic              rst_stb_o,
    output logic              miso_o
);

    localparam int unsigned CNT_W = $clog2(WORD_W) + 1;

    typedef struct packed {
        shi_phase_e        phase;
        logic [CMD_W-1:0]  cmd;
        shi_len_t          len;
        logic [CNT_W-1:0]  bitcnt;
        logic [WORD_W-1:0] shin;
        logic [WORD_W-1:0] shout;
        logic [WORD_W-1:0] wdata;
        logic              load_pend;
        logic              wr_stb;
        logic              rst_stb;
        logic              sclk_prev;
    } core_state_t;

    core_state_t q, d;

    logic              rise, fall;
    logic [WORD_W-1:0] shin_nx;
    logic [CNT_W-1:0]  last_bit;
    shi_len_t          len_nx;

    always_comb begin
        rise     = sclk_s & ~q.sclk_prev;
        fall     = ~sclk_s & q.sclk_prev;
        shin_nx  = {q.shin[WORD_W-2:0], mosi_s};
        last_bit = (q.len.nbytes == 2'd2) ? CNT_W'(WORD_W - 1) : CNT_W'(BYTE_W - 1);
        len_nx   = shi_lookup(shin_nx[CMD_W-1:0]);

        d           = q;
        d.wr_stb    = 1'b0;
        d.rst_stb   = 1'b0;
        d.sclk_prev = sclk_s;

        if (csn_s) begin
            d.phase     = PH_IDLE;
            d.bitcnt    = '0;
            d.load_pend = 1'b0;
        end else begin
            case (q.phase)
                PH_IDLE: begin
                    d.phase  = PH_CMD;
                    d.bitcnt = '0;
                end
                PH_CMD: begin
                    if (rise) begin
                        d.shin   = shin_nx;
                        d.bitcnt = q.bitcnt + 1'b1;
                        if (q.bitcnt == CNT_W'(CMD_W - 1)) begin
                            d.cmd    = shin_nx[CMD_W-1:0];
                            d.len    = len_nx;
                            d.bitcnt = '0;
                            if (len_nx.nbytes == 2'd0) begin
                                d.phase   = PH_DONE;
                                d.rst_stb = (shin_nx[CMD_W-1:0] == RST_CMD);
                            end else if (len_nx.is_rd) begin
                                d.phase     = PH_RD;
                                d.load_pend = 1'b1;
                            end else begin
                                d.phase = PH_WR;
                            end
                        end
                    end
                end
                PH_WR: begin
                    if (rise) begin
                        d.shin   = shin_nx;
                        d.bitcnt = q.bitcnt + 1'b1;
                        if (q.bitcnt == last_bit) begin
                            d.wr_stb = 1'b1;
                            d.wdata  = (q.len.nbytes == 2'd2) ? shin_nx
                                                              : {{BYTE_W{1'b0}}, shin_nx[BYTE_W-1:0]};
                            d.phase  = PH_DONE;
                        end
                    end
                end
                PH_RD: begin
                    if (fall) begin
                        if (q.load_pend) begin
                            d.shout     = (q.len.nbytes == 2'd2) ? rd_data
                                                                 : {rd_data[BYTE_W-1:0], {BYTE_W{1'b0}}};
                            d.load_pend = 1'b0;
                        end else begin
                            d.shout = {q.shout[WORD_W-2:0], 1'b0};
                        end
                    end
                    if (rise) begin
                        d.bitcnt = q.bitcnt + 1'b1;
                        if (q.bitcnt == last_bit) d.phase = PH_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cmd_o     = q.cmd;
    assign wr_data_o = q.wdata;
    assign wr_stb_o  = q.wr_stb;
    assign rst_stb_o = q.rst_stb;
    assign miso_o    = (q.phase == PH_RD) & ~q.load_pend & q.shout[WORD_W-1];

    a_r11_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_stb |=> !q.wr_stb);

    a_r7_rst_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        q.rst_stb |-> !q.wr_stb);

    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (q.phase == PH_IDLE) && !q.wr_stb && !q.rst_stb);

    a_r3_wr_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_stb |-> $past(!csn_s));

    a_r9_done_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_DONE) && ($past(q.phase) == PH_DONE) |-> !q.wr_stb && !q.rst_stb);

endmodule

// File: rtl/shi_host_if.sv
module shi_host_if
    import shi_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sclk,
    input  logic              host_csn,
    input  logic              host_mosi,
    output logic              host_miso,
    input  logic              irq_req,
    output logic              host_irq_n,
    output logic [CMD_W-1:0]  rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic [CMD_W-1:0]  wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_stb,
    output logic              cmd_rst
);

    // Bit order of the synchronised bundle: {csn, sclk, mosi}
    localparam logic [2:0] PIN_RESET = 3'b100;

    logic [2:0]       pins_s;
    logic [CMD_W-1:0] cmd;

    shi_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (PIN_RESET)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({host_csn, host_sclk, host_mosi}),
        .dout  (pins_s)
    );

    shi_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[1]),
        .csn_s     (pins_s[2]),
        .mosi_s    (pins_s[0]),
        .rd_data   (rd_data),
        .cmd_o     (cmd),
        .wr_data_o (wr_data),
        .wr_stb_o  (wr_stb),
        .rst_stb_o (cmd_rst),
        .miso_o    (host_miso)
    );

    shi_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .irq_n   (host_irq_n)
    );

    assign rd_addr = cmd;
    assign wr_addr = cmd;

    a_r13_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pins_s[2] |=> !host_miso);

endmodule

// File: tb/shi_host_if_tb_top.sv
module shi_host_if_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8 * CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sclk = 1'b0;
    logic        host_csn = 1'b1;
    logic        host_mosi = 1'b0;
    logic        host_miso;
    logic        irq_req = 1'b0;
    logic        host_irq_n;
    logic [7:0]  rd_addr;
    logic [15:0] rd_data;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;
    logic        wr_stb;
    logic        cmd_rst;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit mon_on = 1'b0;

    typedef struct { logic [7:0] a; logic [15:0] d; } wr_t;
    wr_t exp_wr[$];
    int  exp_rst = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] rd_model(input logic [7:0] a);
        return {a, ~a} ^ 16'h5A3C;
    endfunction

    assign rd_data = rd_model(rd_addr);

    shi_host_if dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sclk  (host_sclk),
        .host_csn   (host_csn),
        .host_mosi  (host_mosi),
        .host_miso  (host_miso),
        .irq_req    (irq_req),
        .host_irq_n (host_irq_n),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_stb     (wr_stb),
        .cmd_rst    (cmd_rst)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bench_len(input logic [7:0] c, output int n, output bit rd);
        n = 0; rd = 1'b0;
        if (c >= 8'h60 && c <= 8'h6F) n = 1;
        else if ((c >= 8'h70 && c <= 8'h7F) || (c >= 8'hD0 && c <= 8'hDF)) n = 2;
        else if (c >= 8'hE0 && c <= 8'hEF) begin n = 2; rd = 1'b1; end
        else if (c >= 8'hF0) begin n = 1; rd = 1'b1; end
    endtask

    task automatic frame(input logic [7:0] cmd, input logic [15:0] dat, input int nbits);
        logic [31:0] v;
        logic [15:0] erd;
        int  n;
        bit  rd;
        wr_t w;
        v = {cmd, dat, 8'hC3};
        bench_len(cmd, n, rd);
        erd = (n == 2) ? rd_model(cmd) : {rd_model(cmd)[7:0], 8'h00};
        if (nbits >= 8 && cmd == 8'h01) exp_rst++;
        if (!rd && n > 0 && nbits >= 8 + 8 * n) begin
            w.a = cmd;
            w.d = (n == 2) ? dat : {8'h00, dat[15:8]};
            exp_wr.push_back(w);
        end
        host_csn = 1'b0;
        #HALF;
        for (int i = 0; i < nbits; i++) begin
            host_mosi = v[31-i];
            #HALF;
            if (rd && i >= 8 && i < 8 + 8 * n)
                chk(host_miso === erd[15-(i-8)], (n == 2) ? "R5 reply bit" : "R6 reply bit",
                    32'(host_miso), 32'(erd[15-(i-8)]));
            else
                chk(host_miso === 1'b0, "R13 quiet reply line", 32'(host_miso), 32'd0);
            host_sclk = 1'b1;
            #HALF;
            host_sclk = 1'b0;
        end
        if (rd && nbits >= 8)
            chk(rd_addr === cmd, "R5 read address", 32'(rd_addr), 32'(cmd));
        #HALF;
        host_csn = 1'b1;
        repeat (8) @(negedge clk);
        chk(exp_wr.size() == 0, "R3 R8 pending write count", 32'(exp_wr.size()), 32'd0);
        chk(exp_rst == 0, "R7 pending reset strobes", 32'(exp_rst), 32'd0);
    endtask

    // Every-clock comparison against the model
    bit prev_stb = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            chk(host_irq_n === ~irq_req, "R12 interrupt pin", 32'(host_irq_n), 32'(~irq_req));
            chk(!(prev_stb && wr_stb), "R11 single-cycle strobe", 32'(wr_stb), 32'd0);
            if (wr_stb) begin
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R8 R9 R10 unexpected write", 32'({wr_addr, wr_data}), 32'd0);
                end else begin
                    wr_t w;
                    w = exp_wr.pop_front();
                    chk(wr_addr === w.a, "R3 write address", 32'(wr_addr), 32'(w.a));
                    chk(wr_data === w.d, "R2 R4 write data", 32'(wr_data), 32'(w.d));
                end
            end
            if (cmd_rst) begin
                chk(exp_rst > 0, "R7 unexpected reset strobe", 32'(cmd_rst), 32'd0);
                if (exp_rst > 0) exp_rst--;
            end
            prev_stb = wr_stb;
        end
    end

    // Interrupt request stimulus, changed just after falling edges
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            #1;
            k++;
            irq_req = (k % 7 == 3) || (k % 11 == 5);
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(wr_stb === 1'b0 && cmd_rst === 1'b0 && host_miso === 1'b0, "R1 outputs in reset",
            32'({wr_stb, cmd_rst, host_miso}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_stb === 1'b0 && cmd_rst === 1'b0 && host_miso === 1'b0, "R1 outputs after reset",
            32'({wr_stb, cmd_rst, host_miso}), 32'd0);
        mon_on = 1'b1;
        repeat (4) @(negedge clk);

        frame(8'h72, 16'hBEEF, 24);   // R3 two-byte write
        frame(8'hD5, 16'h1234, 24);   // R3 second range
        frame(8'h6A, 16'h9C00, 16);   // R4 one-byte write
        frame(8'hE3, 16'h0000, 24);   // R5 two-byte read
        frame(8'hF7, 16'h0000, 16);   // R6 one-byte read
        frame(8'h01, 16'h0000, 8);    // R7 reset command
        frame(8'h7F, 16'hAAAA, 20);   // R8 aborted in data
        frame(8'hD0, 16'h5555, 5);    // R8 aborted in command
        frame(8'h71, 16'h0F0F, 32);   // R9 extra bits after write
        frame(8'h01, 16'hFFFF, 24);   // R9 extra bits after reset command
        frame(8'h42, 16'h3C3C, 24);   // R10 unlisted command
        frame(8'h00, 16'hFFFF, 24);   // R10 unlisted command
        frame(8'hEF, 16'h0000, 32);   // R5 R9 read with extra bits
        frame(8'hDF, 16'h8001, 24);   // R2 edge bits of word

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule